// File: doc/BRIEF.md
# Two-Stage Redial Digit Buffer

This block records every digit code accepted during one off-hook session of a telephone dialer and plays the record back when the redial key is pressed. Digits pulled from repertory locations arrive on the same strobe as keypad digits, so mixed and cascaded numbers are recorded as one sequence. Pause and pulse-to-tone switch codes are stored and replayed like any other entry.

A session that begins by dialing fresh digits overwrites the buffer. A session that begins with redial keeps the old contents, and any digits keyed after that redial are appended behind them. A split index then marks where the appended part starts. In a later session the first redial press replays only the original part, and a second press replays the appended part. Sessions that try to store more entries than the buffer holds make redial unavailable until a later session fits.

Replayed codes leave on a valid/ready stream. The tone and pulse generators downstream accept them at their own pace.

Top module: `redial_buffer`

## Requirements
- R1: After reset, rp_valid is low and the buffer holds no valid number, so a redial press produces no replay.
- R2: Codes 0 to 9 are digits, 10 is star, 11 is hash, 12 is pause and 13 is pulse-to-tone. All of them are stored and replayed. Codes 14 and 15 are dropped and take no entry.
- R3: The first digit of a session that has not used redial clears the buffer. A later redial then replays exactly the codes of that session, in dialing order.
- R4: While rp_valid is high and rp_ready is low, rp_valid stays high and rp_code does not change. Each cycle with both high moves the replay on by one entry.
- R5: Digits keyed after a redial in the same session are appended. In a later session, the first redial replays only the original part and the second redial replays only the appended part.
- R6: A redial press is ignored in a session that has already dialed fresh digits. It is also ignored after a redial when no second stage is pending.
- R7: Up to DEPTH entries are replayed in full. One entry more makes the buffer invalid, and redial stays ignored until a fresh session stores a number that fits.
- R8: Going on-hook (hook_off low) ends the session and stops a running replay, so rp_valid is low one cycle later. Digits and redial presses are ignored while on-hook.
- R9: Digit strobes and redial presses that arrive while a replay is running are ignored. They neither change the buffer nor cancel a pending second stage.
- R10: A session that dials nothing leaves the buffer and its split unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hook_off | input | 1 | High while the handset is off-hook |
| dig_vld | input | 1 | One-cycle strobe for a dialed code |
| dig_code | input | CODE_W | Code of the dialed entry |
| redial_key | input | 1 | One-cycle redial key strobe |
| rp_ready | input | 1 | Downstream accepts the current replay code |
| rp_valid | output | 1 | A replay code is presented |
| rp_code | output | CODE_W | Replayed code |

## Verification
The bench builds the block with DEPTH set to 8 and CODE_W set to 4. With that depth, a full buffer and a one-entry overflow can each be reached with a single table row of nine codes. The same short buffer still leaves room for the two-stage sequence and for stalled replays. At the default depth, the overflow boundary would need more than thirty keyed digits for every case.

// File: rtl/rdl_pkg.sv
package rdl_pkg;

   typedef enum logic [2:0] {
      SS_ONHOOK,
      SS_FRESH,
      SS_NEWNUM,
      SS_REDIAL,
      SS_LOCKED
   } sess_e;

   localparam int unsigned CODE_PAUSE = 12;
   localparam int unsigned CODE_P2T   = 13;
   localparam int unsigned CODE_TOP   = CODE_P2T;

endpackage

// File: rtl/rdl_store.sv
module rdl_store #(
   parameter int unsigned DEPTH       = 32,
   parameter int unsigned CODE_W      = 4,
   parameter bit          RESET_STORE = 1'b1,
   localparam int unsigned LEN_W      = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [LEN_W-1:0]  wr_idx,
   input  logic [CODE_W-1:0] wr_code,
   input  logic [LEN_W-1:0]  rd_idx,
   output logic [CODE_W-1:0] rd_code
);

   localparam int unsigned FLAT_W = DEPTH * CODE_W;

   logic [FLAT_W-1:0] flat;

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic [CODE_W-1:0] q;
      logic              hit;

      assign hit = wr_en && (wr_idx == LEN_W'(g));

      if (RESET_STORE) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= wr_code;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (hit) q <= wr_code;
         end
      end

      assign flat[g*CODE_W +: CODE_W] = q;
   end

   always_comb begin
      rd_code = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (rd_idx == LEN_W'(k)) rd_code = flat[k*CODE_W +: CODE_W];
      end
   end

endmodule

// File: rtl/rdl_replay.sv
module rdl_replay #(
   parameter int unsigned DEPTH  = 32,
   localparam int unsigned LEN_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] first_idx,
   input  logic [LEN_W-1:0] stop_idx,
   input  logic             abort,
   input  logic             out_ready,
   output logic             busy,
   output logic [LEN_W-1:0] rd_idx
);

   logic [LEN_W-1:0] ptr_q;
   logic [LEN_W-1:0] stop_q;
   logic             busy_q;
   logic             last_beat;

   assign last_beat = (ptr_q + LEN_W'(1)) == stop_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         stop_q <= '0;
         busy_q <= 1'b0;
      end else if (abort) begin
         busy_q <= 1'b0;
      end else if (start && !busy_q) begin
         ptr_q  <= first_idx;
         stop_q <= stop_idx;
         busy_q <= first_idx != stop_idx;
      end else if (busy_q && out_ready) begin
         ptr_q <= ptr_q + LEN_W'(1);
         if (last_beat) busy_q <= 1'b0;
      end
   end

   assign busy   = busy_q;
   assign rd_idx = ptr_q;

endmodule

// File: rtl/rdl_session.sv
module rdl_session
   import rdl_pkg::*;
#(
   parameter int unsigned DEPTH  = 32,
   parameter int unsigned CODE_W = 4,
   localparam int unsigned LEN_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hook_off,
   input  logic              dig_vld,
   input  logic [CODE_W-1:0] dig_code,
   input  logic              redial_key,
   input  logic              busy,
   output logic              wr_en,
   output logic [LEN_W-1:0]  wr_idx,
   output logic              start,
   output logic [LEN_W-1:0]  first_idx,
   output logic [LEN_W-1:0]  stop_idx,
   output logic [LEN_W-1:0]  len,
   output logic [LEN_W-1:0]  split,
   output logic              num_ok
);

   sess_e            st_q, st_n;
   logic [LEN_W-1:0] len_q, len_n;
   logic [LEN_W-1:0] split_q, split_n;
   logic             ok_q, ok_n;
   logic             pend_q, pend_n;
   logic             app_q, app_n;
   logic             take_dig;
   logic             take_key;
   logic             full;

   assign take_key = hook_off && !busy && redial_key;
   assign take_dig = hook_off && !busy && !redial_key && dig_vld
                     && (dig_code <= CODE_W'(CODE_TOP));
   assign full     = len_q == LEN_W'(DEPTH);

   always_comb begin
      st_n      = st_q;
      len_n     = len_q;
      split_n   = split_q;
      ok_n      = ok_q;
      pend_n    = pend_q;
      app_n     = app_q;
      wr_en     = 1'b0;
      wr_idx    = len_q;
      start     = 1'b0;
      first_idx = '0;
      stop_idx  = len_q;

      unique case (st_q)
         SS_ONHOOK: begin
            if (hook_off) begin
               st_n  = SS_FRESH;
               app_n = 1'b0;
            end
         end
         SS_FRESH: begin
            if (take_key && ok_q) begin
               start    = 1'b1;
               stop_idx = (split_q != '0) ? split_q : len_q;
               pend_n   = split_q != '0;
               st_n     = SS_REDIAL;
            end else if (take_dig) begin
               wr_en   = 1'b1;
               wr_idx  = '0;
               len_n   = LEN_W'(1);
               split_n = '0;
               ok_n    = 1'b1;
               st_n    = SS_NEWNUM;
            end
         end
         SS_NEWNUM: begin
            if (take_dig) begin
               if (full) begin
                  ok_n = 1'b0;
                  st_n = SS_LOCKED;
               end else begin
                  wr_en = 1'b1;
                  len_n = len_q + LEN_W'(1);
               end
            end
         end
         SS_REDIAL: begin
            if (take_key && pend_q) begin
               start     = 1'b1;
               first_idx = split_q;
               stop_idx  = len_q;
               pend_n    = 1'b0;
            end else if (take_dig) begin
               pend_n = 1'b0;
               if (full) begin
                  ok_n = 1'b0;
                  st_n = SS_LOCKED;
               end else begin
                  wr_en = 1'b1;
                  len_n = len_q + LEN_W'(1);
                  if (!app_q) begin
                     split_n = len_q;
                     app_n   = 1'b1;
                  end
               end
            end
         end
         SS_LOCKED: begin
         end
         default: st_n = SS_ONHOOK;
      endcase

      if (!hook_off) begin
         st_n   = SS_ONHOOK;
         pend_n = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SS_ONHOOK;
         len_q   <= '0;
         split_q <= '0;
         ok_q    <= 1'b0;
         pend_q  <= 1'b0;
         app_q   <= 1'b0;
      end else begin
         st_q    <= st_n;
         len_q   <= len_n;
         split_q <= split_n;
         ok_q    <= ok_n;
         pend_q  <= pend_n;
         app_q   <= app_n;
      end
   end

   assign len    = len_q;
   assign split  = split_q;
   assign num_ok = ok_q;

endmodule

// File: rtl/redial_buffer.sv
module redial_buffer #(
   parameter int unsigned DEPTH       = 32,
   parameter int unsigned CODE_W      = 4,
   parameter bit          RESET_STORE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hook_off,
   input  logic              dig_vld,
   input  logic [CODE_W-1:0] dig_code,
   input  logic              redial_key,
   input  logic              rp_ready,
   output logic              rp_valid,
   output logic [CODE_W-1:0] rp_code
);

   localparam int unsigned LEN_W = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("redial_buffer: DEPTH must be at least 2");
   end
   if (CODE_W < 4) begin : g_bad_code
      $error("redial_buffer: CODE_W must be at least 4");
   end

   logic             wr_en_w;
   logic [LEN_W-1:0] wr_idx_w;
   logic             start_w;
   logic [LEN_W-1:0] first_w;
   logic [LEN_W-1:0] stop_w;
   logic [LEN_W-1:0] len_w;
   logic [LEN_W-1:0] split_w;
   logic             valid_w;
   logic             busy_w;
   logic [LEN_W-1:0] rd_idx_w;

   rdl_session #(
      .DEPTH  (DEPTH),
      .CODE_W (CODE_W)
   ) sess_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .hook_off   (hook_off),
      .dig_vld    (dig_vld),
      .dig_code   (dig_code),
      .redial_key (redial_key),
      .busy       (busy_w),
      .wr_en      (wr_en_w),
      .wr_idx     (wr_idx_w),
      .start      (start_w),
      .first_idx  (first_w),
      .stop_idx   (stop_w),
      .len        (len_w),
      .split      (split_w),
      .num_ok     (valid_w)
   );

   rdl_store #(
      .DEPTH       (DEPTH),
      .CODE_W      (CODE_W),
      .RESET_STORE (RESET_STORE)
   ) store_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en_w),
      .wr_idx  (wr_idx_w),
      .wr_code (dig_code),
      .rd_idx  (rd_idx_w),
      .rd_code (rp_code)
   );

   rdl_replay #(
      .DEPTH (DEPTH)
   ) play_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start_w),
      .first_idx (first_w),
      .stop_idx  (stop_w),
      .abort     (!hook_off),
      .out_ready (rp_ready),
      .busy      (busy_w),
      .rd_idx    (rd_idx_w)
   );

   assign rp_valid = busy_w;

endmodule

// File: rtl/redial_buffer_chk.sv
module redial_buffer_chk #(
   parameter int unsigned DEPTH  = 32,
   parameter int unsigned CODE_W = 4,
   parameter int unsigned LEN_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hook_off,
   input logic              rp_ready,
   input logic              rp_valid,
   input logic [CODE_W-1:0] rp_code,
   input logic [LEN_W-1:0]  len,
   input logic [LEN_W-1:0]  split,
   input logic              valid,
   input logic              wr_en,
   input logic              busy
);

   // R4
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rp_valid && !rp_ready && hook_off |=> rp_valid && $stable(rp_code));

   // R8
   onhook_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hook_off |=> !rp_valid);

   // R7
   len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      len <= LEN_W'(DEPTH));

   // R7
   valid_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> len != '0);

   // R5
   split_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      split != '0 |-> split < len);

   // R9
   no_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !busy);

endmodule

bind redial_buffer redial_buffer_chk #(
   .DEPTH  (DEPTH),
   .CODE_W (CODE_W),
   .LEN_W  (LEN_W)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .hook_off (hook_off),
   .rp_ready (rp_ready),
   .rp_valid (rp_valid),
   .rp_code  (rp_code),
   .len      (len_w),
   .split    (split_w),
   .valid    (valid_w),
   .wr_en    (wr_en_w),
   .busy     (busy_w)
);

// File: tb/redial_buffer_tb_top.sv
`timescale 1ns/100ps
module redial_buffer_tb_top;

   localparam int DEPTH  = 8;
   localparam int CODE_W = 4;

   // {stall, count, ten codes with code 0 in the low nibble}
   localparam logic [44:0] VECS [6] = '{
      {1'b0, 4'd3, 40'h0000000321},
      {1'b1, 4'd5, 40'h00000ABD0C},
      {1'b1, 4'd8, 40'h0023456789},
      {1'b0, 4'd9, 40'h0987654321},
      {1'b0, 4'd4, 40'h000000F5E4},
      {1'b1, 4'd1, 40'h0000000000}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              hook_off = 1'b0;
   logic              dig_vld = 1'b0;
   logic [CODE_W-1:0] dig_code = '0;
   logic              redial_key = 1'b0;
   logic              rp_ready = 1'b1;
   logic              rp_valid;
   logic [CODE_W-1:0] rp_code;

   int total = 0;
   int bad = 0;
   logic [3:0] got [16];
   int got_n;
   logic [3:0] exp_q [16];
   int exp_n;

   always #2.5 clk = ~clk;

   redial_buffer #(.DEPTH(DEPTH), .CODE_W(CODE_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .hook_off(hook_off), .dig_vld(dig_vld),
      .dig_code(dig_code), .redial_key(redial_key), .rp_ready(rp_ready),
      .rp_valid(rp_valid), .rp_code(rp_code)
   );

   task automatic check(input string tag, input int act, input int expv);
      total++;
      if (act != expv) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic set_hook(input logic v);
      hook_off = v;
      repeat (2) @(negedge clk);
   endtask

   task automatic dial(input logic [3:0] c);
      dig_code = c;
      dig_vld  = 1'b1;
      @(negedge clk);
      dig_vld  = 1'b0;
      @(negedge clk);
   endtask

   task automatic press_redial();
      redial_key = 1'b1;
      @(negedge clk);
      redial_key = 1'b0;
   endtask

   task automatic collect(input logic stall);
      got_n = 0;
      for (int i = 0; i < 40; i++) begin
         rp_ready = stall ? (i % 3 == 2) : 1'b1;
         if (rp_valid && rp_ready && got_n < 16) begin
            got[got_n] = rp_code;
            got_n++;
         end
         @(negedge clk);
      end
      rp_ready = 1'b1;
   endtask

   task automatic expect_clear();
      exp_n = 0;
   endtask

   task automatic expect_add(input logic [3:0] c);
      exp_q[exp_n] = c;
      exp_n++;
   endtask

   task automatic compare(input string tag);
      check({tag, " count"}, got_n, exp_n);
      for (int k = 0; k < exp_n && k < got_n; k++)
         check({tag, " code"}, int'(got[k]), int'(exp_q[k]));
   endtask

   initial begin
      #100000;
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 rp_valid in reset", int'(rp_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rp_valid after reset", int'(rp_valid), 0);
      set_hook(1'b1);
      press_redial();
      collect(1'b0);
      expect_clear();
      compare("R1 redial with empty buffer");
      set_hook(1'b0);

      // Table walk: R2 R3 R4 R7
      for (int v = 0; v < 6; v++) begin
         logic [44:0] e;
         int n;
         e = VECS[v];
         n = int'(e[43:40]);
         expect_clear();
         set_hook(1'b1);
         for (int k = 0; k < n; k++) begin
            logic [3:0] c;
            c = e[k*4 +: 4];
            dial(c);
            if (c <= 4'd13) expect_add(c);
         end
         if (exp_n > DEPTH) expect_clear();
         set_hook(1'b0);
         set_hook(1'b1);
         press_redial();
         collect(e[44]);
         compare($sformatf("R2 R3 R4 R7 vector %0d", v));
         set_hook(1'b0);
      end

      // R5, R9, R4: two-stage replay
      set_hook(1'b1);
      dial(4'd1);
      dial(4'd2);
      set_hook(1'b0);
      set_hook(1'b1);
      rp_ready = 1'b0;
      press_redial();
      check("R4 valid while stalled", int'(rp_valid), 1);
      check("R4 first code while stalled", int'(rp_code), 1);
      dig_code = 4'd7;
      dig_vld = 1'b1;
      redial_key = 1'b1;
      @(negedge clk);
      dig_vld = 1'b0;
      redial_key = 1'b0;
      @(negedge clk);
      check("R4 code held", int'(rp_code), 1);
      collect(1'b0);
      expect_clear(); expect_add(4'd1); expect_add(4'd2);
      compare("R9 replay ignores strobes");
      dial(4'd3);
      dial(4'd4);
      set_hook(1'b0);
      set_hook(1'b1);
      press_redial();
      collect(1'b0);
      compare("R5 first stage");
      press_redial();
      collect(1'b1);
      expect_clear(); expect_add(4'd3); expect_add(4'd4);
      compare("R5 second stage");
      press_redial();
      collect(1'b0);
      expect_clear();
      compare("R6 no pending stage");
      set_hook(1'b0);
      set_hook(1'b1);
      press_redial();
      collect(1'b0);
      expect_clear(); expect_add(4'd1); expect_add(4'd2);
      compare("R5 split kept across sessions");
      set_hook(1'b0);

      // R6, R3, R10
      set_hook(1'b1);
      dial(4'd5);
      dial(4'd6);
      press_redial();
      collect(1'b0);
      expect_clear();
      compare("R6 redial after fresh digits");
      set_hook(1'b0);
      set_hook(1'b1);
      set_hook(1'b0);
      set_hook(1'b1);
      press_redial();
      collect(1'b0);
      expect_clear(); expect_add(4'd5); expect_add(4'd6);
      compare("R3 R10 replaced buffer kept");

      // R8
      rp_ready = 1'b0;
      set_hook(1'b0);
      set_hook(1'b1);
      press_redial();
      check("R8 replay running", int'(rp_valid), 1);
      hook_off = 1'b0;
      @(negedge clk);
      check("R8 on-hook stops replay", int'(rp_valid), 0);
      rp_ready = 1'b1;
      dial(4'd9);
      press_redial();
      @(negedge clk);
      check("R8 on-hook ignores redial", int'(rp_valid), 0);
      set_hook(1'b1);
      press_redial();
      collect(1'b0);
      compare("R8 buffer untouched on-hook");
      set_hook(1'b0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule